// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers the interrupt sources of a multi-channel DMA engine and drives one combined interrupt line. The sources fall into three groups. The transmit group has one completion source per transmit channel. The receive group has one completion source per receive channel. The error group has a single host-error source. Each source arrives as a one-cycle pulse that latches a raw status bit. The bit stays set until the matching acknowledge input clears it. The DMA engine raises that acknowledge when software writes back the channel's completion pointer.

Software works through a 32-bit register port. Each group offers four views:

- raw status
- masked status
- a mask register that takes write-one-to-set
- the same mask register through a write-one-to-clear address

A vector register gathers every masked pending bit in one word.

The combined line follows an arm-and-acknowledge scheme. When it fires, it disarms itself. It can only fire again after software writes zero to the end-of-interrupt register. So every service pass gives a fresh rising edge when work is still pending.

Top module: `dma_irq_aggregator`

## Requirements
- R1: A pulse on a source input sets its raw bit at the next clock edge. The bit stays set until acknowledged. If a pulse and an acknowledge reach the same bit in the same cycle, the bit ends up set.
- R2: An acknowledge input clears its raw bit at the next clock edge.
- R3: Writing to the mask-set address sets every mask bit whose data bit is 1 and leaves the others unchanged. Reading the mask-set address returns the current mask. After reset all masks are zero.
- R4: Writing to the mask-clear address clears every mask bit whose data bit is 1. A write of all ones disables the whole group in one access. Reading the mask-clear address also returns the current mask.
- R5: The masked view reads raw AND mask. Writes to the raw and masked addresses are ignored. The raw view does not depend on the mask.
- R6: Bit positions:
  - Transmit group: raw 0x80, masked 0x84, mask-set 0x88, mask-clear 0x8C.
  - Receive group: raw 0xA0, masked 0xA4, mask-set 0xA8, mask-clear 0xAC.
  - In both groups, channel n uses bit n.
  - Error group: raw 0xB0, masked 0xB4, mask-set 0xB8, mask-clear 0xBC.
  - In the error group, host error is bit 1. All other bits read zero and cannot be set.
- R7: While armed, the combined output rises one cycle after any masked bit becomes pending. Rising disarms the block.
- R8: While disarmed, the output never rises again. It falls one cycle after no masked bit is pending.
- R9: Writing zero to 0x94 (end of interrupt) drives the output low at the next edge and re-arms the block. If anything is still pending, the output rises again one cycle later. A nonzero write to 0x94 has no effect.
- R10: The vector register at 0x90 reads as follows:
  - bits [N-1:0]: masked transmit status
  - bits [2N-1:N]: masked receive status
  - bit 2N: masked host error
- R11: A read presents data on the cycle after the read strobe. The data shows the state just before that edge. Unmapped or misaligned addresses read zero. After reset all readable state is zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done | input | NUM_CH | Transmit completion pulses, one per channel |
| tx_ack | input | NUM_CH | Transmit completion acknowledges |
| rx_done | input | NUM_CH | Receive completion pulses, one per channel |
| rx_ack | input | NUM_CH | Receive completion acknowledges |
| host_err | input | 1 | Host error pulse |
| host_err_ack | input | 1 | Host error acknowledge |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after reg_rd |
| irq_out | output | 1 | Combined interrupt |

## Verification
A corrupt raw or mask bit shows up at most one cycle later. It appears in the masked view, in the vector word, and in the level of `irq_out`. A stuck or missing arm flag gives one of two symptoms:
- a second rising edge with no end-of-interrupt write in between, or
- no rising edge one cycle after such a write while work is pending.

The bench therefore compares `irq_out` on every cycle against a model built from the requirements, and compares every read word against the same model.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 32;
    localparam int ERR_W        = 2;
    localparam int HOST_ERR_BIT = 1;

    // upper address nibbles that select each block of registers
    localparam logic [3:0] NIB_TX   = 4'h8;
    localparam logic [3:0] NIB_MISC = 4'h9;
    localparam logic [3:0] NIB_RX   = 4'hA;
    localparam logic [3:0] NIB_ERR  = 4'hB;

    // only host error is implemented in the error group
    localparam logic [ERR_W-1:0] ERR_IMPL = 2'b10;

    typedef enum logic [1:0] {
        GRP_TX   = 2'd0,
        GRP_RX   = 2'd1,
        GRP_ERR  = 2'd2,
        GRP_NONE = 2'd3
    } irq_grp_e;

    // order follows address bits [3:2] inside a group
    typedef enum logic [1:0] {
        VIEW_RAW    = 2'd0,
        VIEW_MASKED = 2'd1,
        VIEW_MSET   = 2'd2,
        VIEW_MCLR   = 2'd3
    } irq_view_e;

    typedef enum logic [1:0] {
        MISC_NONE   = 2'd0,
        MISC_VECTOR = 2'd1,
        MISC_EOI    = 2'd2
    } misc_e;

    typedef struct packed {
        irq_grp_e  grp;
        irq_view_e view;
        misc_e     misc;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.grp  = GRP_NONE;
        s.view = irq_view_e'(a[3:2]);
        s.misc = MISC_NONE;
        if (a[1:0] == 2'b00) begin
            if (a[7:4] == NIB_TX)       s.grp = GRP_TX;
            else if (a[7:4] == NIB_RX)  s.grp = GRP_RX;
            else if (a[7:4] == NIB_ERR) s.grp = GRP_ERR;
            else if (a[7:4] == NIB_MISC) begin
                if (a[3:2] == 2'd0)      s.misc = MISC_VECTOR;
                else if (a[3:2] == 2'd1) s.misc = MISC_EOI;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_src_group.sv
module irq_src_group #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   IMPL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src_pulse,
    input  logic [W-1:0] src_ack,
    input  logic         mset_we,
    input  logic         mclr_we,
    input  logic [W-1:0] wr_bits,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] masked_o,
    output logic         any_o
);
    logic [W-1:0] raw_q;
    logic [W-1:0] mask_q;

    // a new pulse takes priority over an acknowledge on the same bit
    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
        end else begin
            raw_q <= ((raw_q & ~src_ack) | src_pulse) & IMPL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mset_we) begin
            mask_q <= (mask_q | wr_bits) & IMPL;
        end else if (mclr_we) begin
            mask_q <= mask_q & ~wr_bits;
        end
    end

    assign raw_o    = raw_q;
    assign mask_o   = mask_q;
    assign masked_o = raw_q & mask_q;
    assign any_o    = |(raw_q & mask_q);
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import dma_irq_pkg::*;
(
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [2:0]        mset_we,
    output logic [2:0]        mclr_we,
    output logic              eoi_wr
);
    reg_sel_t sel;

    always_comb begin
        sel     = decode_addr(reg_addr);
        mset_we = '0;
        mclr_we = '0;
        if (reg_wr && sel.grp != GRP_NONE) begin
            if (sel.view == VIEW_MSET) mset_we[sel.grp] = 1'b1;
            if (sel.view == VIEW_MCLR) mclr_we[sel.grp] = 1'b1;
        end
        eoi_wr = reg_wr && (sel.misc == MISC_EOI) && (reg_wdata == '0);
    end
endmodule

// File: rtl/irq_arm_ctrl.sv
module irq_arm_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic pending,
    input  logic eoi,
    output logic irq_o
);
    logic armed_q;
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            irq_q   <= 1'b0;
        end else if (eoi) begin
            armed_q <= 1'b1;
            irq_q   <= 1'b0;
        end else if (armed_q && pending) begin
            armed_q <= 1'b0;
            irq_q   <= 1'b1;
        end else if (!pending) begin
            irq_q   <= 1'b0;
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] tx_done,
    input  logic [NUM_CH-1:0] tx_ack,
    input  logic [NUM_CH-1:0] rx_done,
    input  logic [NUM_CH-1:0] rx_ack,
    input  logic              host_err,
    input  logic              host_err_ack,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);
    // vector word holds both channel groups plus host error; NUM_CH <= 15
    localparam int VEC_HOST = 2 * NUM_CH;

    logic [2:0]        mset_we;
    logic [2:0]        mclr_we;
    logic              eoi_wr;

    logic [NUM_CH-1:0] ch_done   [2];
    logic [NUM_CH-1:0] ch_ack    [2];
    logic [NUM_CH-1:0] ch_raw    [2];
    logic [NUM_CH-1:0] ch_mask   [2];
    logic [NUM_CH-1:0] ch_masked [2];
    logic [1:0]        ch_any;

    logic [ERR_W-1:0]  err_raw;
    logic [ERR_W-1:0]  err_mask;
    logic [ERR_W-1:0]  err_masked;
    logic              err_any;
    logic              pending;

    reg_sel_t          rsel;
    logic [DATA_W-1:0] rd_val;

    assign ch_done[0] = tx_done;
    assign ch_done[1] = rx_done;
    assign ch_ack[0]  = tx_ack;
    assign ch_ack[1]  = rx_ack;

    irq_reg_decode u_dec (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .mset_we  (mset_we),
        .mclr_we  (mclr_we),
        .eoi_wr   (eoi_wr)
    );

    // index 0 = transmit, 1 = receive, matching the group enum
    for (genvar g = 0; g < 2; g++) begin : g_chan
        irq_src_group #(.W(NUM_CH)) u_grp (
            .clk      (clk),
            .rst      (rst),
            .src_pulse(ch_done[g]),
            .src_ack  (ch_ack[g]),
            .mset_we  (mset_we[g]),
            .mclr_we  (mclr_we[g]),
            .wr_bits  (reg_wdata[NUM_CH-1:0]),
            .raw_o    (ch_raw[g]),
            .mask_o   (ch_mask[g]),
            .masked_o (ch_masked[g]),
            .any_o    (ch_any[g])
        );
    end

    irq_src_group #(.W(ERR_W), .IMPL(ERR_IMPL)) u_err (
        .clk      (clk),
        .rst      (rst),
        .src_pulse({host_err, 1'b0}),
        .src_ack  ({host_err_ack, 1'b0}),
        .mset_we  (mset_we[GRP_ERR]),
        .mclr_we  (mclr_we[GRP_ERR]),
        .wr_bits  (reg_wdata[ERR_W-1:0]),
        .raw_o    (err_raw),
        .mask_o   (err_mask),
        .masked_o (err_masked),
        .any_o    (err_any)
    );

    assign pending = (|ch_any) | err_any;

    irq_arm_ctrl u_arm (
        .clk    (clk),
        .rst    (rst),
        .pending(pending),
        .eoi    (eoi_wr),
        .irq_o  (irq_out)
    );

    always_comb begin
        rsel   = decode_addr(reg_addr);
        rd_val = '0;
        if (rsel.grp == GRP_TX || rsel.grp == GRP_RX) begin
            int gi;
            gi = (rsel.grp == GRP_RX) ? 1 : 0;
            case (rsel.view)
                VIEW_RAW:    rd_val[NUM_CH-1:0] = ch_raw[gi];
                VIEW_MASKED: rd_val[NUM_CH-1:0] = ch_masked[gi];
                default:     rd_val[NUM_CH-1:0] = ch_mask[gi];
            endcase
        end else if (rsel.grp == GRP_ERR) begin
            case (rsel.view)
                VIEW_RAW:    rd_val[ERR_W-1:0] = err_raw;
                VIEW_MASKED: rd_val[ERR_W-1:0] = err_masked;
                default:     rd_val[ERR_W-1:0] = err_mask;
            endcase
        end else if (rsel.misc == MISC_VECTOR) begin
            rd_val[NUM_CH-1:0]        = ch_masked[0];
            rd_val[2*NUM_CH-1:NUM_CH] = ch_masked[1];
            rd_val[VEC_HOST]          = err_masked[HOST_ERR_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_val;
        end
    end
endmodule

// File: rtl/dma_irq_aggregator_chk.sv
module dma_irq_aggregator_chk
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] tx_done,
    input logic [NUM_CH-1:0] tx_ack,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq_out,
    input logic              pending,
    input logic [NUM_CH-1:0] tx_raw,
    input logic [NUM_CH-1:0] tx_mask
);
    // R1: pulses land in the raw register
    a_r1_pulse_sets_raw: assert property (@(posedge clk) disable iff (rst)
        (|tx_done) |=> ((tx_raw & $past(tx_done)) == $past(tx_done)));

    // R2: acknowledge without a competing pulse clears
    a_r2_ack_clears_raw: assert property (@(posedge clk) disable iff (rst)
        (|(tx_ack & ~tx_done)) |=> ((tx_raw & $past(tx_ack & ~tx_done)) == '0));

    // R3: set-only mask write
    a_r3_mask_set: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 8'h88)
        |=> ((tx_mask & $past(reg_wdata[NUM_CH-1:0])) == $past(reg_wdata[NUM_CH-1:0])));

    // R4: clear-only mask write
    a_r4_mask_clr: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 8'h8C)
        |=> ((tx_mask & $past(reg_wdata[NUM_CH-1:0])) == '0));

    // R8: the output is never high without pending work the cycle before
    a_r8_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> $past(pending));

    // R9: end of interrupt drops the output
    a_r9_eoi_lowers: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 8'h94 && reg_wdata == '0) |=> !irq_out);
endmodule

bind dma_irq_aggregator dma_irq_aggregator_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_done  (tx_done),
    .tx_ack   (tx_ack),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .irq_out  (irq_out),
    .pending  (pending),
    .tx_raw   (ch_raw[0]),
    .tx_mask  (ch_mask[0])
);

// File: tb/tb_dma_irq_aggregator.sv
module tb_dma_irq_aggregator;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  tx_done = '0, tx_ack = '0, rx_done = '0, rx_ack = '0;
    logic          host_err = 1'b0, host_err_ack = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model built from the requirements
    logic [N-1:0] m_tx_raw, m_tx_mask, m_rx_raw, m_rx_mask;
    logic         m_he_raw, m_he_mask, m_armed, m_irq;

    always #2 clk = ~clk;

    dma_irq_aggregator #(.NUM_CH(N)) dut (
        .clk(clk), .rst(rst),
        .tx_done(tx_done), .tx_ack(tx_ack),
        .rx_done(rx_done), .rx_ack(rx_ack),
        .host_err(host_err), .host_err_ack(host_err_ack),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            8'h80: v[N-1:0] = m_tx_raw;
            8'h84: v[N-1:0] = m_tx_raw & m_tx_mask;
            8'h88, 8'h8C: v[N-1:0] = m_tx_mask;
            8'hA0: v[N-1:0] = m_rx_raw;
            8'hA4: v[N-1:0] = m_rx_raw & m_rx_mask;
            8'hA8, 8'hAC: v[N-1:0] = m_rx_mask;
            8'hB0: v[1] = m_he_raw;
            8'hB4: v[1] = m_he_raw & m_he_mask;
            8'hB8, 8'hBC: v[1] = m_he_mask;
            8'h90: begin
                v[N-1:0]   = m_tx_raw & m_tx_mask;
                v[2*N-1:N] = m_rx_raw & m_rx_mask;
                v[2*N]     = m_he_raw & m_he_mask;
            end
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_tx_raw = '0; m_tx_mask = '0; m_rx_raw = '0; m_rx_mask = '0;
        m_he_raw = 1'b0; m_he_mask = 1'b0; m_armed = 1'b1; m_irq = 1'b0;
    endtask

    // one clock: model next state, edge, compare, release strobes
    task automatic tick();
        logic [31:0] exp_rd;
        logic        did_rd, pend, eoi;
        logic [N-1:0] n_txm, n_rxm;
        logic        n_hem;
        exp_rd = model_read(reg_addr);
        did_rd = reg_rd;
        pend = (|(m_tx_raw & m_tx_mask)) | (|(m_rx_raw & m_rx_mask)) | (m_he_raw & m_he_mask);
        eoi  = reg_wr && reg_addr == 8'h94 && reg_wdata == 32'h0;
        n_txm = m_tx_mask; n_rxm = m_rx_mask; n_hem = m_he_mask;
        if (reg_wr) begin
            case (reg_addr)
                8'h88: n_txm = m_tx_mask | reg_wdata[N-1:0];
                8'h8C: n_txm = m_tx_mask & ~reg_wdata[N-1:0];
                8'hA8: n_rxm = m_rx_mask | reg_wdata[N-1:0];
                8'hAC: n_rxm = m_rx_mask & ~reg_wdata[N-1:0];
                8'hB8: n_hem = m_he_mask | reg_wdata[1];
                8'hBC: n_hem = m_he_mask & ~reg_wdata[1];
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        m_tx_raw = (m_tx_raw & ~tx_ack) | tx_done;
        m_rx_raw = (m_rx_raw & ~rx_ack) | rx_done;
        m_he_raw = (m_he_raw & ~host_err_ack) | host_err;
        m_tx_mask = n_txm; m_rx_mask = n_rxm; m_he_mask = n_hem;
        if (eoi) begin
            m_armed = 1'b1; m_irq = 1'b0;
        end else if (m_armed && pend) begin
            m_armed = 1'b0; m_irq = 1'b1;
        end else if (!pend) begin
            m_irq = 1'b0;
        end
        chk("R7 irq level vs model", {31'b0, irq_out}, {31'b0, m_irq});
        if (did_rd) chk("R11 read vs model", reg_rdata, exp_rd);
        tx_done = '0; tx_ack = '0; rx_done = '0; rx_ack = '0;
        host_err = 1'b0; host_err_ack = 1'b0;
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        reg_rd = 1'b1; reg_addr = a;
        tick();
        chk(req, reg_rdata, exp);
    endtask

    task automatic irq_chk(input logic exp, input string req);
        chk(req, {31'b0, irq_out}, {31'b0, exp});
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] wr_list [8];
        logic [7:0] rd_list [17];
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state (R11)
        irq_chk(1'b0, "R11 irq low after reset");
        rd_chk(8'h80, 32'h0, "R11 tx raw reset");
        rd_chk(8'h88, 32'h0, "R11 tx mask reset");
        rd_chk(8'hA8, 32'h0, "R11 rx mask reset");
        rd_chk(8'hB8, 32'h0, "R11 err mask reset");
        rd_chk(8'h90, 32'h0, "R11 vector reset");

        // mask set / clear (R3, R4)
        wr(8'h88, 32'h0000_00A5);
        rd_chk(8'h88, 32'hA5, "R3 mask set readback");
        rd_chk(8'h8C, 32'hA5, "R4 mask read via clear address");
        wr(8'h88, 32'h0);
        rd_chk(8'h88, 32'hA5, "R3 zero write leaves mask");
        wr(8'h8C, 32'h0000_0021);
        rd_chk(8'h88, 32'h84, "R4 clear selected bits");

        // raw capture and masking (R1, R5, R6)
        tx_done[3] = 1'b1; tick();
        rd_chk(8'h80, 32'h08, "R1 pulse sets tx channel 3 raw bit 3");
        rd_chk(8'h84, 32'h00, "R5 masked view hides unmasked bit");
        irq_chk(1'b0, "R7 no irq for masked-off source");
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'h84, 32'hFFFF_FFFF);
        rd_chk(8'h80, 32'h08, "R5 raw write ignored");
        wr(8'h8C, 32'hFFFF_FFFF);
        rd_chk(8'h88, 32'h00, "R4 all ones clears whole group");
        tx_done[0] = 1'b1; tx_ack[0] = 1'b1; tick();
        rd_chk(8'h80, 32'h09, "R1 pulse wins over same-cycle ack");
        tx_ack[3] = 1'b1; tick();
        rd_chk(8'h80, 32'h01, "R2 ack clears raw bit");
        rx_done[5] = 1'b1; tick();
        rd_chk(8'hA0, 32'h20, "R6 rx channel 5 on bit 5");
        host_err = 1'b1; tick();
        rd_chk(8'hB0, 32'h02, "R6 host error on bit 1");

        // interrupt sequencing (R6, R7, R8, R9, R10)
        wr(8'hB8, 32'hFFFF_FFFF);
        irq_chk(1'b0, "R7 not yet high on mask edge");
        rd_chk(8'hB8, 32'h02, "R6 only bit 1 of error mask exists");
        irq_chk(1'b1, "R7 irq high one cycle after pending");
        rd_chk(8'hB4, 32'h02, "R5 error masked view");
        rd_chk(8'h90, 32'h0001_0000, "R10 vector host error bit");
        host_err_ack = 1'b1; tick();
        irq_chk(1'b1, "R8 irq held the cycle of the ack");
        tick();
        irq_chk(1'b0, "R8 irq falls when nothing pending");
        wr(8'hA8, 32'h20);
        tick(); tick();
        irq_chk(1'b0, "R8 no rise while disarmed");
        rd_chk(8'h90, 32'h0000_2000, "R10 vector rx bit 13");
        wr(8'h94, 32'h1);
        tick();
        irq_chk(1'b0, "R9 nonzero eoi ignored");
        wr(8'h94, 32'h0);
        irq_chk(1'b0, "R9 eoi edge keeps irq low");
        tick();
        irq_chk(1'b1, "R9 re-rise after eoi with pending");
        wr(8'h94, 32'h0);
        irq_chk(1'b0, "R9 eoi drops a high irq");
        tick();
        irq_chk(1'b1, "R9 second re-rise");
        wr(8'hAC, 32'hFFFF_FFFF);
        irq_chk(1'b1, "R8 irq holds on mask-clear edge");
        tick();
        irq_chk(1'b0, "R8 irq falls after mask cleared");
        rd_chk(8'h98, 32'h0, "R11 unmapped reads zero");
        rd_chk(8'h82, 32'h0, "R11 misaligned reads zero");

        // constrained random phase
        wr_list = '{8'h88, 8'h8C, 8'hA8, 8'hAC, 8'hB8, 8'hBC, 8'h94, 8'h80};
        rd_list = '{8'h80, 8'h84, 8'h88, 8'h8C, 8'hA0, 8'hA4, 8'hA8, 8'hAC,
                    8'hB0, 8'hB4, 8'hB8, 8'hBC, 8'h90, 8'h94, 8'h98, 8'h00, 8'hC0};
        for (int i = 0; i < 4000; i++) begin
            tx_done = N'($urandom & $urandom & $urandom);
            rx_done = N'($urandom & $urandom & $urandom);
            tx_ack  = N'($urandom & $urandom);
            rx_ack  = N'($urandom & $urandom);
            host_err     = ($urandom % 16) == 0;
            host_err_ack = ($urandom % 8) == 0;
            if (($urandom % 4) == 0) begin
                reg_wr    = 1'b1;
                reg_addr  = wr_list[$urandom % 8];
                reg_wdata = (reg_addr == 8'h94 && ($urandom % 2) == 0) ? 32'h0 : $urandom;
            end else if (($urandom % 2) == 0) begin
                reg_rd   = 1'b1;
                reg_addr = rd_list[$urandom % 17];
            end
            tick();
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule